// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronised Updates

This block produces four independent pulse-width modulated waveforms, each programmed through a small word-addressed register port. Every channel owns a power-of-two clock divider, a 16-bit up-counter that wraps after reaching its period value, a compare against an active duty value, and a polarity bit applied after the compare. A larger duty value yields a shorter active time, since the output is inactive while the count sits below the duty value.

Software configures a stopped channel by writing its duty and period registers directly. Once the channel runs, changes go through separate update registers and are applied only when the current period ends, so a waveform never carries a torn period. Stopping is also synchronised: a disable request is honoured at the next period end, and the status bit reports the channel as on until that moment. Each period end raises a per-channel flag in an interrupt-status register that clears on read; a single interrupt line is high while any flag is pending.

The register port is a single-cycle strobe interface: a write strobe with address and data, and a read strobe whose data appears on the read bus one clock later and holds until the next read.

Top module: `pwm_quad`

## Requirements
- R1: After reset every channel is stopped, all waveform outputs are low, the interrupt line is low, and status, interrupt-status and every channel register read as zero.
- R2: A running channel with period value P, duty value D (D not above P) and prescale exponent E repeats every (P+1)*2^E clocks and is active (high at normal polarity) for (P+1-D)*2^E of them.
- R3: Duty value 0 keeps a running channel active for the whole period; a duty value above the period value keeps it inactive for the whole period.
- R4: Bits [3:0] of a channel's mode register (window offset 0x00) set the prescale exponent E; a written value above 10 is stored and read back as 10.
- R5: Mode register bit 9 inverts the channel output; a stopped channel drives the level of that bit (low when 0, high when 1).
- R6: On a stopped channel, writes to the duty register (offset 0x04) and period register (offset 0x0C) take effect at once and keep only the low 16 bits, which read back.
- R7: On a running channel, writes to the duty and period registers at offsets 0x04 and 0x0C are ignored.
- R8: On a running channel, writes to the duty-update (0x08) and period-update (0x10) registers are held and copied into the active duty and period at the next period end; reads of 0x04 and 0x0C return the active values.
- R9: At each period end of channel n, bit n of the interrupt-status register (0x1C) is set; a read returns the accumulated bits and clears them, and the interrupt line is high while any bit is set.
- R10: Writing a mask to the enable register (0x04) starts every stopped channel whose bit is 1, from count 0; bit n of the status register (0x0C) reads 1 while channel n runs.
- R11: Writing a mask to the disable register (0x08) stops each selected running channel at its next period end; until then its status bit stays 1, afterwards it reads 0 and the output returns to its idle level.
- R12: Channel n's registers sit at 0x200 + n*0x20; reads of any other offset return zero and writes to them change nothing; read data is valid the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| pwm_o | output | 4 | Waveform output per channel |
| irq_o | output | 1 | High while any interrupt-status bit is set |

## Verification
The bench targets the duty extremes (zero and above the period), where an off-by-one compare would leave a stray active or inactive cycle each period, and the prescaler clamp, where an unclamped exponent would read back as written and stretch the period. It writes update registers just after start-up on a long period, so a design that applied them immediately, or honoured base-register writes while running, shows the new value before the period end. It reads the interrupt status twice across a boundary, catching a flag that never clears or one lost on read, and reads status right after a disable, catching a channel that stops mid-period or keeps its status bit after stopping.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // global register offsets
  localparam logic [11:0] OFS_ENA  = 12'h004;
  localparam logic [11:0] OFS_DIS  = 12'h008;
  localparam logic [11:0] OFS_STAT = 12'h00C;
  localparam logic [11:0] OFS_ISR  = 12'h01C;

  // offsets inside a channel window
  localparam logic [4:0] WIN_MODE = 5'h00;
  localparam logic [4:0] WIN_DUTY = 5'h04;
  localparam logic [4:0] WIN_DUPD = 5'h08;
  localparam logic [4:0] WIN_PER  = 5'h0C;
  localparam logic [4:0] WIN_PUPD = 5'h10;

  localparam int MODE_POL_BIT = 9;
  localparam int PRES_FW      = 4;

  typedef struct packed {
    logic mode;
    logic duty;
    logic dupd;
    logic per;
    logic pupd;
  } chan_wr_t;

endpackage

// File: rtl/pwm_quad_presc.sv
module pwm_quad_presc #(
  parameter int PRE_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic [pwm_quad_pkg::PRES_FW-1:0] pres,
  output logic                      tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = ~({PRE_W{1'b1}} << pres);
  assign tick = ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PRES_MAX = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  chan_wr_t           wr,
  input  logic [DW-1:0]      wdata,
  input  logic [PRES_FW-1:0] mode_pres,
  input  logic               mode_pol,
  input  logic               en_req,
  input  logic               dis_req,
  output logic               run_o,
  output logic               bnd_o,
  output logic               pol_o,
  output logic [PRES_FW-1:0] pres_o,
  output logic [DW-1:0]      duty_o,
  output logic [DW-1:0]      dupd_o,
  output logic [DW-1:0]      per_o,
  output logic [DW-1:0]      pupd_o,
  output logic               wave_o
);

  localparam logic [PRES_FW-1:0] PRES_TOP = PRES_FW'(PRES_MAX);

  logic               run_q, stop_q, pol_q, wave_q;
  logic               dpend_q, ppend_q;
  logic [PRES_FW-1:0] pres_q;
  logic [DW-1:0]      duty_q, dupd_q, per_q, pupd_q, cnt_q;
  logic               tick, at_end;

  pwm_quad_presc #(.PRE_W(PRES_MAX)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .clr  (!run_q),
    .pres (pres_q),
    .tick (tick)
  );

  assign at_end = run_q && tick && (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      stop_q  <= 1'b0;
      pol_q   <= 1'b0;
      pres_q  <= '0;
      duty_q  <= '0;
      dupd_q  <= '0;
      per_q   <= '0;
      pupd_q  <= '0;
      cnt_q   <= '0;
      dpend_q <= 1'b0;
      ppend_q <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      // counting and period end
      if (run_q && tick) begin
        if (cnt_q == per_q) begin
          cnt_q <= '0;
          if (dpend_q) duty_q <= dupd_q;
          if (ppend_q) per_q  <= pupd_q;
          dpend_q <= 1'b0;
          ppend_q <= 1'b0;
          if (stop_q) begin
            run_q  <= 1'b0;
            stop_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      // register writes (later assignments win over the period end)
      if (wr.mode) begin
        pres_q <= (mode_pres > PRES_TOP) ? PRES_TOP : mode_pres;
        pol_q  <= mode_pol;
      end
      if (wr.duty && !run_q) duty_q <= wdata;
      if (wr.per  && !run_q) per_q  <= wdata;
      if (wr.dupd) begin
        dupd_q <= wdata;
        if (run_q) dpend_q <= 1'b1;
        else       duty_q  <= wdata;
      end
      if (wr.pupd) begin
        pupd_q <= wdata;
        if (run_q) ppend_q <= 1'b1;
        else       per_q   <= wdata;
      end

      // start and stop requests
      if (en_req && !run_q) begin
        run_q   <= 1'b1;
        stop_q  <= 1'b0;
        cnt_q   <= '0;
        dpend_q <= 1'b0;
        ppend_q <= 1'b0;
      end
      if (dis_req && run_q) stop_q <= 1'b1;

      wave_q <= (run_q && (cnt_q >= duty_q)) ^ pol_q;
    end
  end

  assign run_o  = run_q;
  assign bnd_o  = at_end;
  assign pol_o  = pol_q;
  assign pres_o = pres_q;
  assign duty_o = duty_q;
  assign dupd_o = dupd_q;
  assign per_o  = per_q;
  assign pupd_o = pupd_q;
  assign wave_o = wave_q;

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 16,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o,
  output logic              irq_o
);

  localparam int WIN_LSB = 5;
  localparam int IDX_W   = 4;
  localparam int PAGE_W  = ADDR_W - (WIN_LSB + IDX_W);

  logic              glob_sel, win_sel;
  logic [IDX_W-1:0]  win_idx;
  logic [4:0]        win_off;
  logic              isr_rd;
  logic [NCH-1:0]    run_vec, bnd_vec, pol_vec, flag_q;
  logic [NCH*DW-1:0] duty_flat;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  logic [PRES_FW-1:0] pres_a [NCH];
  logic [DW-1:0]      duty_a [NCH];
  logic [DW-1:0]      dupd_a [NCH];
  logic [DW-1:0]      per_a  [NCH];
  logic [DW-1:0]      pupd_a [NCH];

  logic unused_hi;
  assign unused_hi = ^bus_wdata[DATA_W-1:DW];

  assign glob_sel = (bus_addr[ADDR_W-1 -: PAGE_W] == '0);
  assign win_idx  = bus_addr[WIN_LSB +: IDX_W];
  assign win_off  = bus_addr[WIN_LSB-1:0];
  assign win_sel  = (bus_addr[ADDR_W-1 -: PAGE_W] == PAGE_W'(1)) &&
                    (32'(win_idx) < NCH);
  assign isr_rd   = bus_rd && glob_sel && (bus_addr == ADDR_W'(OFS_ISR));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_wr_t ws;
    logic     hit, en_r, dis_r;

    assign hit     = bus_wr && win_sel && (32'(win_idx) == i);
    assign ws.mode = hit && (win_off == WIN_MODE);
    assign ws.duty = hit && (win_off == WIN_DUTY);
    assign ws.dupd = hit && (win_off == WIN_DUPD);
    assign ws.per  = hit && (win_off == WIN_PER);
    assign ws.pupd = hit && (win_off == WIN_PUPD);
    assign en_r    = bus_wr && glob_sel && (bus_addr == ADDR_W'(OFS_ENA)) && bus_wdata[i];
    assign dis_r   = bus_wr && glob_sel && (bus_addr == ADDR_W'(OFS_DIS)) && bus_wdata[i];

    pwm_quad_chan #(.DW(DW), .PRES_MAX(PRES_MAX)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr        (ws),
      .wdata     (bus_wdata[DW-1:0]),
      .mode_pres (bus_wdata[PRES_FW-1:0]),
      .mode_pol  (bus_wdata[MODE_POL_BIT]),
      .en_req    (en_r),
      .dis_req   (dis_r),
      .run_o     (run_vec[i]),
      .bnd_o     (bnd_vec[i]),
      .pol_o     (pol_vec[i]),
      .pres_o    (pres_a[i]),
      .duty_o    (duty_a[i]),
      .dupd_o    (dupd_a[i]),
      .per_o     (per_a[i]),
      .pupd_o    (pupd_a[i]),
      .wave_o    (pwm_o[i])
    );

    assign duty_flat[i*DW +: DW] = duty_a[i];
  end

  // interrupt flags: a read clears what it returned, new period ends survive
  always_ff @(posedge clk) begin
    if (rst)         flag_q <= '0;
    else if (isr_rd) flag_q <= bnd_vec;
    else             flag_q <= flag_q | bnd_vec;
  end

  assign irq_o = |flag_q;

  always_comb begin
    rd_mux = '0;
    if (glob_sel) begin
      if (bus_addr == ADDR_W'(OFS_STAT)) rd_mux = DATA_W'(run_vec);
      if (bus_addr == ADDR_W'(OFS_ISR))  rd_mux = DATA_W'(flag_q);
    end else if (win_sel) begin
      for (int k = 0; k < NCH; k++) begin
        if (32'(win_idx) == k) begin
          case (win_off)
            WIN_MODE: begin
              rd_mux[PRES_FW-1:0]  = pres_a[k];
              rd_mux[MODE_POL_BIT] = pol_vec[k];
            end
            WIN_DUTY: rd_mux = DATA_W'(duty_a[k]);
            WIN_DUPD: rd_mux = DATA_W'(dupd_a[k]);
            WIN_PER:  rd_mux = DATA_W'(per_a[k]);
            WIN_PUPD: rd_mux = DATA_W'(pupd_a[k]);
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    run_vec,
  input logic [NCH-1:0]    bnd_vec,
  input logic [NCH-1:0]    pol_vec,
  input logic [NCH-1:0]    flag_q,
  input logic              isr_rd,
  input logic [NCH*DW-1:0] duty_flat,
  input logic [NCH-1:0]    pwm_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
      !run_vec[i] |=> (pwm_o[i] == $past(pol_vec[i])));  // R5
    AST_STOP_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
      $fell(run_vec[i]) |-> $past(bnd_vec[i]));  // R11
    AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
      bnd_vec[i] |=> flag_q[i]);  // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (isr_rd && !bnd_vec[i]) |=> !flag_q[i]);  // R9
    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (rst)
      (run_vec[i] && !bnd_vec[i]) |=> $stable(duty_flat[i*DW +: DW]));  // R8
  end

endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_vec   (run_vec),
  .bnd_vec   (bnd_vec),
  .pol_vec   (pol_vec),
  .flag_q    (flag_q),
  .isr_rd    (isr_rd),
  .duty_flat (duty_flat),
  .pwm_o     (pwm_o)
);

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwm_quad dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  // {channel, prescale exponent, polarity, period, duty}
  localparam logic [43:0] VEC [6] = '{
    44'h000_0009_0003,
    44'h120_0004_0002,
    44'h201_0007_0002,
    44'h310_0005_0000,
    44'h000_0003_0009,
    44'h131_0002_0001
  };

  function automatic logic [11:0] cba(int ch, int off);
    return 12'(32'h200 + ch * 32 + off);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic count_high(int ch, int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_o[ch]) hi++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pwm_o", 32'(pwm_o), 0);
    check("R1 irq_o", 32'(irq_o), 0);
    rd(12'h00C, v); check("R1 status", v, 0);
    rd(12'h01C, v); check("R1 isr", v, 0);
    rd(cba(0, 0), v); check("R1 mode", v, 0);
    rd(cba(3, 12), v); check("R1 period", v, 0);

    // R4 clamp of prescale exponent
    wr(cba(1, 0), 32'h0000_000F);
    rd(cba(1, 0), v); check("R4 clamp", v, 32'h0000_000A);

    // R5 idle level follows polarity
    wr(cba(2, 0), 32'h0000_0200);
    repeat (2) @(negedge clk);
    check("R5 idle inverted", 32'(pwm_o[2]), 1);
    rd(cba(2, 0), v); check("R5 mode read", v, 32'h0000_0200);

    // R12 unmapped offsets
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, v); check("R12 unmapped read", v, 0);
    wr(cba(1, 20), 32'h1234);
    rd(cba(1, 20), v); check("R12 window hole", v, 0);
    wr(12'h010, 32'hF);
    rd(12'h00C, v); check("R12 no side effect", v, 0);

    // table of waveforms: R2, R3, R4, R5, R11
    foreach (VEC[i]) begin
      int ch, pe, po, pr, du, n, exp_hi;
      ch = int'(VEC[i][43:40]);
      pe = int'(VEC[i][39:36]);
      po = int'(VEC[i][35:32]);
      pr = int'(VEC[i][31:16]);
      du = int'(VEC[i][15:0]);
      n  = (pr + 1) << pe;
      exp_hi = (du > pr) ? 0 : ((pr + 1 - du) << pe);
      if (po != 0) exp_hi = n - exp_hi;
      wr(cba(ch, 0), 32'(pe) | (po != 0 ? 32'h200 : 32'h0));
      wr(cba(ch, 12), 32'(pr));
      wr(cba(ch, 4), 32'(du));
      wr(12'h004, 32'(1) << ch);
      repeat (3 * n + 4) @(negedge clk);
      count_high(ch, n, hi);
      check((du == 0 || du > pr) ? "R3 duty extreme" : "R2 active time", 32'(hi), 32'(exp_hi));
      wr(12'h008, 32'(1) << ch);
      repeat (n + 4) @(negedge clk);
      rd(12'h00C, v); check("R11 stopped", v & (32'(1) << ch), 0);
      check("R5 idle after stop", 32'(pwm_o[ch]), 32'(po != 0));
    end

    // R6 direct writes on a stopped channel
    wr(cba(3, 12), 32'hFFFF_1234);
    rd(cba(3, 12), v); check("R6 period direct", v, 32'h1234);
    wr(cba(3, 4), 32'h0000_ABCD);
    rd(cba(3, 4), v); check("R6 duty direct", v, 32'hABCD);
    wr(cba(3, 12), 32'h5);
    wr(cba(3, 4), 32'h0);

    // R10 multi-channel enable and disable masks
    wr(12'h004, 32'hA);
    rd(12'h00C, v); check("R10 status mask", v, 32'hA);
    wr(12'h008, 32'hA);
    repeat (60) @(negedge clk);
    rd(12'h00C, v); check("R10 all stopped", v, 0);

    // R7 / R8 buffered updates on a long period
    wr(cba(0, 0), 32'h0);
    wr(cba(0, 12), 32'd99);
    wr(cba(0, 4), 32'd10);
    wr(12'h004, 32'h1);
    wr(cba(0, 8), 32'd60);
    rd(cba(0, 4), v); check("R8 duty held", v, 32'd10);
    wr(cba(0, 4), 32'd77);
    rd(cba(0, 4), v); check("R7 duty write ignored", v, 32'd10);
    wr(cba(0, 12), 32'd33);
    wr(cba(0, 16), 32'd79);
    rd(cba(0, 12), v); check("R7 period write ignored", v, 32'd99);
    rd(cba(0, 8), v); check("R8 update reg read", v, 32'd60);
    repeat (120) @(negedge clk);
    rd(cba(0, 4), v); check("R8 duty applied", v, 32'd60);
    rd(cba(0, 12), v); check("R8 period applied", v, 32'd79);
    count_high(0, 80, hi);
    check("R8 new waveform", 32'(hi), 32'd20);
    wr(12'h008, 32'h1);
    repeat (100) @(negedge clk);

    // R9 interrupt status and R11 disable timing
    rd(12'h01C, v);
    rd(12'h01C, v); check("R9 cleared", v, 0);
    wr(cba(2, 0), 32'h0);
    wr(cba(2, 12), 32'd199);
    wr(cba(2, 4), 32'd50);
    wr(12'h004, 32'h4);
    repeat (205) @(negedge clk);
    check("R9 irq line", 32'(irq_o), 1);
    rd(12'h01C, v); check("R9 flag set", v, 32'h4);
    check("R9 irq line low", 32'(irq_o), 0);
    rd(12'h01C, v); check("R9 clear on read", v, 0);
    wr(12'h008, 32'h4);
    rd(12'h00C, v); check("R11 status until end", v, 32'h4);
    repeat (250) @(negedge clk);
    rd(12'h00C, v); check("R11 status dropped", v, 0);
    check("R11 idle level", 32'(pwm_o[2]), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule